// File: doc/BRIEF.md
# Branch Condition Evaluator

This unit decides whether a short conditional branch is taken, and it computes where the branch goes. It takes a 4-bit condition selector, an 8-bit signed displacement, the current program counter and the four condition flags: negative, zero, overflow and carry. Each cycle it registers three results: a taken decision, the branch target and a flag for the reserved selector.

The selector is arranged so that bit 3 inverts the sense of the test chosen by bits 2:0. Selector 0000 is the unconditional branch. Its inverse, 1000, is reserved. The displacement counts halfwords, so the target is the program counter plus twice the sign-extended displacement. The target is produced for every selector, whether or not the branch is taken. The flags are only read, never written.

Flag generation and instruction fetch belong to neighbouring units. The registered outputs let a sequencer or a bench apply one selector/flag combination per cycle and read the result on the next edge.

Top module: `branch_eval`

## Requirements
- R1: Selector 0000 gives taken=1 for every flag combination.
- R2: Selectors 0001, 0010, 0011 and 0100 give taken equal to the negative, zero, overflow and carry flag, in that order.
- R3: Selectors 1001, 1010, 1011 and 1100 give taken equal to the inverse of the negative, zero, overflow and carry flag, in that order.
- R4: Selector 0101 (signed less-than) is taken when negative differs from overflow; selector 1101 is taken when they are equal.
- R5: Selector 0110 (signed less-or-equal) is taken when negative differs from overflow or zero is set; selector 1110 is taken when negative equals overflow and zero is clear.
- R6: Selector 0111 (unsigned less-or-equal) is taken when carry is clear or zero is set; selector 1111 is taken when carry is set and zero is clear.
- R7: Selector 1000 gives taken=0 and illegal_instr=1; every other selector gives illegal_instr=0.
- R8: target equals pc plus the sign-extended displacement shifted left by one, modulo 2^PC_W, for every selector and every flag value.
- R9: taken, target and illegal_instr show the inputs sampled at the previous rising clock edge; while rst_n is low all three are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_code | input | 4 | Condition selector; bit 3 inverts the test |
| disp | input | 8 | Signed displacement in halfwords |
| pc | input | 32 | Current program counter |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| taken | output | 1 | Registered branch decision |
| target | output | 32 | Registered branch target |
| illegal_instr | output | 1 | Registered reserved-selector indication |

## Verification
Every result is due exactly one rising edge after its inputs are presented. Nothing in the block spans more than one cycle, so the decision, the target and the reserved flag all arrive together. The bench changes inputs on the falling edge, waits for the next rising edge, and then samples shortly after it. Each check therefore compares one registered result against the one stimulus that produced it. The sweep covers all sixteen selectors against all sixteen flag patterns. Directed displacement extremes and a wrapping program counter exercise the target, and seeded random cases are mixed in.

// File: rtl/branch_eval_pkg.sv
package branch_eval_pkg;

    typedef enum logic [2:0] {
        TEST_ALWAYS = 3'd0,
        TEST_NEG    = 3'd1,
        TEST_ZERO   = 3'd2,
        TEST_OVF    = 3'd3,
        TEST_CARRY  = 3'd4,
        TEST_SLT    = 3'd5,
        TEST_SLE    = 3'd6,
        TEST_ULE    = 3'd7
    } base_test_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/branch_cond_decode.sv
module branch_cond_decode
    import branch_eval_pkg::*;
(
    input  logic [3:0] code,
    input  flags_t     flags,
    output logic       take,
    output logic       reserved
);
    base_test_e base;
    logic       base_true;
    logic       invert;

    assign base   = base_test_e'(code[2:0]);
    assign invert = code[3];

    always_comb begin
        unique case (base)
            TEST_ALWAYS: base_true = 1'b1;
            TEST_NEG:    base_true = flags.n;
            TEST_ZERO:   base_true = flags.z;
            TEST_OVF:    base_true = flags.v;
            TEST_CARRY:  base_true = flags.c;
            TEST_SLT:    base_true = flags.n ^ flags.v;
            TEST_SLE:    base_true = (flags.n ^ flags.v) | flags.z;
            TEST_ULE:    base_true = ~flags.c | flags.z;
            default:     base_true = 1'b0;
        endcase
    end

    always_comb begin
        reserved = invert && (base == TEST_ALWAYS);
        take     = reserved ? 1'b0 : (base_true ^ invert);
    end

    always_comb begin
        if (reserved) begin
            assert_reserved_not_taken_R7: assert (!take);
        end
    end
endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc #(
    parameter int PC_W   = 32,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   target
);
    localparam int EXT_W = PC_W - DISP_W - 1;

    logic [PC_W-1:0] offset;

    assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
    assign target = pc + offset;

    always_comb begin
        assert_halfword_align_R8: assert (target[0] == pc[0]);
    end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import branch_eval_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cond_code,
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   pc,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    output logic              taken,
    output logic [PC_W-1:0]   target,
    output logic              illegal_instr
);
    flags_t          flags;
    logic            take_d;
    logic            reserved_d;
    logic [PC_W-1:0] target_d;
    logic            primed;

    assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    branch_cond_decode u_decode (
        .code     (cond_code),
        .flags    (flags),
        .take     (take_d),
        .reserved (reserved_d)
    );

    branch_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
        .pc     (pc),
        .disp   (disp),
        .target (target_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken         <= 1'b0;
            target        <= '0;
            illegal_instr <= 1'b0;
            primed        <= 1'b0;
        end else begin
            taken         <= take_d;
            target        <= target_d;
            illegal_instr <= reserved_d;
            primed        <= 1'b1;
        end
    end

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken && illegal_instr));

    assert_always_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_code) == 4'b0000) |-> taken);

    assert_reserved_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (illegal_instr == ($past(cond_code) == 4'b1000)));

    assert_neg_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_code) == 4'b0001) |-> (taken == $past(flag_n)));

    assert_carry_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_code) == 4'b1100) |-> (taken == !$past(flag_c)));

    assert_target_lsb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (target[0] == $past(pc[0])));
endmodule

// File: tb/branch_eval_test.sv
`timescale 1ns/1ps
module branch_eval_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cond_code = '0;
    logic [7:0]  disp = '0;
    logic [31:0] pc = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic        taken;
    logic [31:0] target;
    logic        illegal_instr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    branch_eval uut (
        .clk(clk), .rst_n(rst_n), .cond_code(cond_code), .disp(disp), .pc(pc),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .taken(taken), .target(target), .illegal_instr(illegal_instr)
    );

    function automatic bit exp_taken(input logic [3:0] c, input bit n, input bit z,
                                     input bit v, input bit cy);
        case (c)
            4'b0000: return 1'b1;
            4'b0001: return n;
            4'b0010: return z;
            4'b0011: return v;
            4'b0100: return cy;
            4'b0101: return n != v;
            4'b0110: return (n != v) || z;
            4'b0111: return !cy || z;
            4'b1000: return 1'b0;
            4'b1001: return !n;
            4'b1010: return !z;
            4'b1011: return !v;
            4'b1100: return !cy;
            4'b1101: return n == v;
            4'b1110: return (n == v) && !z;
            default: return cy && !z;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001, 4'b0010, 4'b0011, 4'b0100: return "R2";
            4'b1001, 4'b1010, 4'b1011, 4'b1100: return "R3";
            4'b0101, 4'b1101: return "R4";
            4'b0110, 4'b1110: return "R5";
            4'b1000: return "R7";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [31:0] exp_target(input logic [31:0] p, input logic [7:0] d);
        longint off;
        off = longint'($signed(d)) * 2;
        return 32'(longint'(p) + off);
    endfunction

    task automatic check_bit(input string req, input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_word(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s target: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, sample 1 ns after the following rising edge (R9).
    task automatic apply(input logic [3:0] c, input logic [3:0] f,
                         input logic [31:0] p, input logic [7:0] d);
        @(negedge clk);
        cond_code = c; {flag_n, flag_z, flag_v, flag_c} = f; pc = p; disp = d;
        @(posedge clk);
        #1;
        check_bit(req_of(c), taken, exp_taken(c, f[3], f[2], f[1], f[0]), "taken");
        check_bit("R7", illegal_instr, (c == 4'b1000), "illegal_instr");
        check_word("R8", target, exp_target(p, d));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        cond_code = 4'b0000; pc = 32'h1234_5678; disp = 8'h10;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset holds all outputs at zero despite active inputs
        check_bit("R9", taken, 1'b0, "taken in reset");
        check_bit("R9", illegal_instr, 1'b0, "illegal in reset");
        check_word("R9", target, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive selector x flag sweep: R1..R7
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                apply(4'(c), 4'(f), 32'h0000_1000 + 32'(c * 64), 8'(f * 3));
            end
        end

        // R8 displacement and wrap corners
        apply(4'b0000, 4'h0, 32'h0000_1000, 8'h7F);
        apply(4'b0000, 4'h0, 32'h0000_1000, 8'h80);
        apply(4'b0000, 4'h0, 32'hFFFF_FFFE, 8'h02);
        apply(4'b1000, 4'hF, 32'h0000_0000, 8'hFF);
        apply(4'b0010, 4'h0, 32'h8000_0001, 8'h00);

        // R9: output holds previous sample; a mid-cycle change is not seen until the edge
        apply(4'b0001, 4'b1000, 32'h0000_2000, 8'h01);
        @(negedge clk);
        flag_n = 1'b0;
        #1;
        check_bit("R9", taken, 1'b1, "taken before edge");
        @(posedge clk);
        #1;
        check_bit("R9", taken, 1'b0, "taken after edge");

        // Seeded random mix
        for (int i = 0; i < 400; i++) begin
            apply(4'($urandom), 4'($urandom), $urandom, 8'($urandom));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule